// File: doc/BRIEF.md
# Issue-Window Reorder Buffer

This block is a circular window of instruction slots placed between decode and the functional units of an out-of-order core. Decode presents one instruction per cycle. Each source arrives either as a value or as the tag of the slot that will produce it. The block gives the instruction a slot, and the index of that slot becomes the rename name of its destination register. When a slot holds a live instruction that has not yet started and whose two operands are both present, it may be issued. When several slots qualify, the oldest one leaves first, with age counted from the retire pointer.

A functional unit finishes by broadcasting the slot tag together with the result and an exception flag. Every waiting operand that carries that tag captures the value, and the producing slot stores the result. Slots retire one per cycle, in program order, and only once they have completed. A retire writes the destination register number and the data to the architectural state. If the retiring slot carries an exception, the window is emptied by moving the allocate pointer back onto the retire pointer. The flush input empties the window in the same way.

Top module: `issue_rob`

## Requirements
- R1: After reset the window is empty. `disp_ready_o` is 1, `disp_tag_o` is 0, and `iss_valid_o`, `cmt_valid_o` and `cmt_exc_o` are 0.
- R2: An accepted dispatch is assigned the slot index shown on `disp_tag_o`. After reset, tags are handed out as 0, 1, 2, … modulo DEPTH. Each accepted dispatch moves to the next index.
- R3: A slot is issued only when both of its sources are present. Issue starts at the earliest in the cycle after the dispatch. It carries the slot's opcode, its two source values and its tag. Each slot is issued exactly once.
- R4: When several slots are ready in the same cycle, the slot closest to the retire pointer in program order is issued. This holds even when that slot has the higher index.
- R5: A completion whose tag matches a waiting source fills that source with `cmp_data_i` and marks it present. The completion counts only for a slot that is live and already issued.
- R6: A source that is not ready at dispatch, whose tag is broadcast in that same cycle, is captured as present with the broadcast data.
- R7: Slots retire strictly in program order, at most one per cycle, and only after they have completed. `cmt_reg_o` is the dispatched destination number and `cmt_data_o` is the completion data. A completed younger slot waits behind an older slot that has not completed.
- R8: After DEPTH dispatches with no retire, `disp_ready_o` is 0. A dispatch presented then is dropped and leaves no slot behind.
- R9: When the retiring slot has its exception flag set, `cmt_exc_o` pulses for one cycle with no `cmt_valid_o`. All slots are discarded, and the next dispatch receives the tag of the excepting slot.
- R10: `flush_i` discards every slot. Nothing dispatched before the flush issues or retires afterwards, and the next dispatch receives the tag at the retire pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | Window can accept a dispatch this cycle |
| disp_op_i | input | OP_W | Opcode |
| disp_s1_rdy_i | input | 1 | Source 1 carries a value (else a tag in its low bits) |
| disp_s1_i | input | DATA_W | Source 1 value or tag |
| disp_s2_rdy_i | input | 1 | Source 2 carries a value (else a tag in its low bits) |
| disp_s2_i | input | DATA_W | Source 2 value or tag |
| disp_dst_i | input | REG_W | Architectural destination register |
| disp_tag_o | output | TAG_W | Slot tag given to the current dispatch |
| iss_valid_o | output | 1 | A slot is issued this cycle |
| iss_tag_o | output | TAG_W | Tag of the issued slot |
| iss_op_o | output | OP_W | Opcode of the issued slot |
| iss_s1_o | output | DATA_W | Source 1 value of the issued slot |
| iss_s2_o | output | DATA_W | Source 2 value of the issued slot |
| cmp_valid_i | input | 1 | Completion broadcast valid |
| cmp_tag_i | input | TAG_W | Tag of the completing slot |
| cmp_data_i | input | DATA_W | Result data |
| cmp_exc_i | input | 1 | Result carries an exception |
| cmt_valid_o | output | 1 | Retire writes architectural state this cycle |
| cmt_reg_o | output | REG_W | Destination register of the retiring slot |
| cmt_data_o | output | DATA_W | Data of the retiring slot |
| cmt_exc_o | output | 1 | Retiring slot raised an exception; window is emptied |
| flush_i | input | 1 | Discard all slots |

## Verification
The checker watches several properties on every cycle. It confirms that an issued slot is live, not yet started and has both operands present, and that the same slot is never issued twice in a row. It also confirms that a retire comes only from a completed slot and moves the retire pointer by one, that a full window never reports ready, and that both a flush and an exception leave the window empty. Some behaviour can only be shown by the bench's scenarios, because it depends on the data that moves: which slot wins when several wake together after the pointers have wrapped, the values that wakeup and same-cycle capture place on the issue port, the register and data sequence at retire when completions arrive out of order, a dropped dispatch while full, and tag reuse after an exception or a flush.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    CMT_IDLE   = 2'd0,
    CMT_RETIRE = 2'd1,
    CMT_KILL   = 2'd2
  } cmt_act_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_en_i,
  input  logic             retire_en_i,
  input  logic             rewind_i,
  output logic [PTR_W-1:0] alloc_ptr_o,
  output logic [PTR_W-1:0] cmt_ptr_o,
  output logic             full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_ptr_o <= '0;
      cmt_ptr_o   <= '0;
    end else if (rewind_i) begin
      alloc_ptr_o <= cmt_ptr_o;
    end else begin
      if (alloc_en_i)  alloc_ptr_o <= alloc_ptr_o + PTR_W'(1);
      if (retire_en_i) cmt_ptr_o   <= cmt_ptr_o + PTR_W'(1);
    end
  end

  // wrap bits differ, index bits match
  assign full_o = (alloc_ptr_o[TAG_W] != cmt_ptr_o[TAG_W]) &&
                  (alloc_ptr_o[TAG_W-1:0] == cmt_ptr_o[TAG_W-1:0]);
endmodule

// File: rtl/rob_oldest_pick.sv
module rob_oldest_pick #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req_i,
  input  logic [TAG_W-1:0] base_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] idx_o
);
  logic [TAG_W-1:0] cand [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_cand
    assign cand[k] = base_i + TAG_W'(k);
  end

  // scan from youngest offset down so the smallest offset wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = base_i;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (req_i[cand[k]]) begin
        valid_o = 1'b1;
        idx_o   = cand[k];
      end
    end
  end
endmodule

// File: rtl/issue_rob.sv
module issue_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  output logic              disp_ready_o,
  input  logic [OP_W-1:0]   disp_op_i,
  input  logic              disp_s1_rdy_i,
  input  logic [DATA_W-1:0] disp_s1_i,
  input  logic              disp_s2_rdy_i,
  input  logic [DATA_W-1:0] disp_s2_i,
  input  logic [REG_W-1:0]  disp_dst_i,
  output logic [TAG_W-1:0]  disp_tag_o,
  output logic              iss_valid_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  output logic [OP_W-1:0]   iss_op_o,
  output logic [DATA_W-1:0] iss_s1_o,
  output logic [DATA_W-1:0] iss_s2_o,
  input  logic              cmp_valid_i,
  input  logic [TAG_W-1:0]  cmp_tag_i,
  input  logic [DATA_W-1:0] cmp_data_i,
  input  logic              cmp_exc_i,
  output logic              cmt_valid_o,
  output logic [REG_W-1:0]  cmt_reg_o,
  output logic [DATA_W-1:0] cmt_data_o,
  output logic              cmt_exc_o,
  input  logic              flush_i
);
  logic [DEPTH-1:0] use_q, exec_q, done_q, exc_q, p1_q, p2_q;
  logic [OP_W-1:0]   op_q  [DEPTH];
  logic [REG_W-1:0]  dst_q [DEPTH];
  logic [DATA_W-1:0] s1_q  [DEPTH];
  logic [DATA_W-1:0] s2_q  [DEPTH];
  logic [DATA_W-1:0] res_q [DEPTH];

  logic [PTR_W-1:0] alloc_ptr, cmt_ptr;
  logic [TAG_W-1:0] alloc_idx, head_idx, pick_idx;
  logic             full, pick_valid, disp_fire, iss_fire, kill_all, cmp_hit;
  logic             cap1, cap2;
  logic [DATA_W-1:0] s1_in, s2_in;
  logic [DEPTH-1:0] rdy_vec;
  cmt_act_e         cmt_act;

  assign alloc_idx = alloc_ptr[TAG_W-1:0];
  assign head_idx  = cmt_ptr[TAG_W-1:0];

  always_comb begin
    cmt_act = CMT_IDLE;
    if (!flush_i && use_q[head_idx] && done_q[head_idx])
      cmt_act = exc_q[head_idx] ? CMT_KILL : CMT_RETIRE;
  end

  assign kill_all     = flush_i || (cmt_act == CMT_KILL);
  assign disp_ready_o = !full && !kill_all;
  assign disp_fire    = disp_valid_i && disp_ready_o;
  assign disp_tag_o   = alloc_idx;

  // completion only counts for a live, started slot
  assign cmp_hit = cmp_valid_i && use_q[cmp_tag_i] && exec_q[cmp_tag_i];
  assign cap1    = !disp_s1_rdy_i && cmp_hit && (disp_s1_i[TAG_W-1:0] == cmp_tag_i);
  assign cap2    = !disp_s2_rdy_i && cmp_hit && (disp_s2_i[TAG_W-1:0] == cmp_tag_i);
  assign s1_in   = cap1 ? cmp_data_i : disp_s1_i;
  assign s2_in   = cap2 ? cmp_data_i : disp_s2_i;

  assign rdy_vec = use_q & ~exec_q & p1_q & p2_q;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_en_i  (disp_fire),
    .retire_en_i (cmt_act == CMT_RETIRE),
    .rewind_i    (kill_all),
    .alloc_ptr_o (alloc_ptr),
    .cmt_ptr_o   (cmt_ptr),
    .full_o      (full)
  );

  rob_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .req_i   (rdy_vec),
    .base_i  (head_idx),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  assign iss_fire    = pick_valid && !kill_all;
  assign iss_valid_o = iss_fire;
  assign iss_tag_o   = pick_idx;
  assign iss_op_o    = op_q[pick_idx];
  assign iss_s1_o    = s1_q[pick_idx];
  assign iss_s2_o    = s2_q[pick_idx];

  assign cmt_valid_o = (cmt_act == CMT_RETIRE);
  assign cmt_exc_o   = (cmt_act == CMT_KILL);
  assign cmt_reg_o   = dst_q[head_idx];
  assign cmt_data_o  = res_q[head_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_q  <= '0;
      exec_q <= '0;
      done_q <= '0;
      exc_q  <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
    end else if (kill_all) begin
      use_q  <= '0;
      exec_q <= '0;
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cmt_act == CMT_RETIRE && head_idx == TAG_W'(i)) use_q[i] <= 1'b0;
        if (use_q[i] && !p1_q[i] && cmp_hit && s1_q[i][TAG_W-1:0] == cmp_tag_i) p1_q[i] <= 1'b1;
        if (use_q[i] && !p2_q[i] && cmp_hit && s2_q[i][TAG_W-1:0] == cmp_tag_i) p2_q[i] <= 1'b1;
        if (iss_fire && pick_idx == TAG_W'(i)) exec_q[i] <= 1'b1;
        if (cmp_hit && cmp_tag_i == TAG_W'(i)) begin
          done_q[i] <= 1'b1;
          exc_q[i]  <= cmp_exc_i;
        end
        if (disp_fire && alloc_idx == TAG_W'(i)) begin
          use_q[i]  <= 1'b1;
          exec_q[i] <= 1'b0;
          done_q[i] <= 1'b0;
          exc_q[i]  <= 1'b0;
          p1_q[i]   <= disp_s1_rdy_i || cap1;
          p2_q[i]   <= disp_s2_rdy_i || cap2;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (use_q[i] && !p1_q[i] && cmp_hit && s1_q[i][TAG_W-1:0] == cmp_tag_i) s1_q[i] <= cmp_data_i;
      if (use_q[i] && !p2_q[i] && cmp_hit && s2_q[i][TAG_W-1:0] == cmp_tag_i) s2_q[i] <= cmp_data_i;
      if (cmp_hit && cmp_tag_i == TAG_W'(i)) res_q[i] <= cmp_data_i;
      if (disp_fire && alloc_idx == TAG_W'(i)) begin
        op_q[i]  <= disp_op_i;
        dst_q[i] <= disp_dst_i;
        s1_q[i]  <= s1_in;
        s2_q[i]  <= s2_in;
      end
    end
  end
endmodule

// File: rtl/issue_rob_chk.sv
module issue_rob_chk #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             disp_ready_o,
  input logic             iss_valid_o,
  input logic [TAG_W-1:0] iss_tag_o,
  input logic             cmt_valid_o,
  input logic             cmt_exc_o,
  input logic             full_i,
  input logic [PTR_W-1:0] alloc_ptr_i,
  input logic [PTR_W-1:0] cmt_ptr_i,
  input logic [DEPTH-1:0] use_i,
  input logic [DEPTH-1:0] exec_i,
  input logic [DEPTH-1:0] p1_i,
  input logic [DEPTH-1:0] p2_i,
  input logic [DEPTH-1:0] done_i
);
  AST_NO_DISP_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> !disp_ready_o); // R8

  AST_SPAN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PTR_W'(alloc_ptr_i - cmt_ptr_i) <= PTR_W'(DEPTH))); // R8

  AST_ISS_OPERANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> (use_i[iss_tag_o] && !exec_i[iss_tag_o] && p1_i[iss_tag_o] && p2_i[iss_tag_o])); // R3

  AST_ISS_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |=> !(iss_valid_o && iss_tag_o == $past(iss_tag_o))); // R3

  AST_CMT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_valid_o |-> (use_i[cmt_ptr_i[TAG_W-1:0]] && done_i[cmt_ptr_i[TAG_W-1:0]])); // R7

  AST_CMT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_valid_o |=> (cmt_ptr_i == $past(cmt_ptr_i) + PTR_W'(1))); // R7

  AST_EXC_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_exc_o |=> (alloc_ptr_i == cmt_ptr_i && use_i == '0)); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (alloc_ptr_i == cmt_ptr_i && use_i == '0)); // R10
endmodule

bind issue_rob issue_rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .disp_ready_o (disp_ready_o),
  .iss_valid_o  (iss_valid_o),
  .iss_tag_o    (iss_tag_o),
  .cmt_valid_o  (cmt_valid_o),
  .cmt_exc_o    (cmt_exc_o),
  .full_i       (full),
  .alloc_ptr_i  (alloc_ptr),
  .cmt_ptr_i    (cmt_ptr),
  .use_i        (use_q),
  .exec_i       (exec_q),
  .p1_i         (p1_q),
  .p2_i         (p2_q),
  .done_i       (done_q)
);

// File: tb/issue_rob_tb.sv
`timescale 1ns/1ps
module issue_rob_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        disp_valid_i = 1'b0;
  logic        disp_ready_o;
  logic [3:0]  disp_op_i = '0;
  logic        disp_s1_rdy_i = 1'b0;
  logic [15:0] disp_s1_i = '0;
  logic        disp_s2_rdy_i = 1'b0;
  logic [15:0] disp_s2_i = '0;
  logic [4:0]  disp_dst_i = '0;
  logic [2:0]  disp_tag_o;
  logic        iss_valid_o;
  logic [2:0]  iss_tag_o;
  logic [3:0]  iss_op_o;
  logic [15:0] iss_s1_o, iss_s2_o;
  logic        cmp_valid_i = 1'b0;
  logic [2:0]  cmp_tag_i = '0;
  logic [15:0] cmp_data_i = '0;
  logic        cmp_exc_i = 1'b0;
  logic        cmt_valid_o;
  logic [4:0]  cmt_reg_o;
  logic [15:0] cmt_data_o;
  logic        cmt_exc_o;
  logic        flush_i = 1'b0;

  always #2.5 clk_i = ~clk_i;

  issue_rob u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] exp_tag = '0;

  int iss_n = 0, cmt_n = 0, exc_n = 0;
  logic [2:0]  iss_tag_l [256];
  logic [3:0]  iss_op_l  [256];
  logic [15:0] iss_s1_l  [256];
  logic [15:0] iss_s2_l  [256];
  logic [4:0]  cmt_reg_l [256];
  logic [15:0] cmt_dat_l [256];

  // event log sampled mid-cycle
  always begin
    @(negedge clk_i);
    #2;
    if (rst_ni) begin
      if (iss_valid_o) begin
        iss_tag_l[iss_n] = iss_tag_o;
        iss_op_l[iss_n]  = iss_op_o;
        iss_s1_l[iss_n]  = iss_s1_o;
        iss_s2_l[iss_n]  = iss_s2_o;
        iss_n++;
      end
      if (cmt_valid_o) begin
        cmt_reg_l[cmt_n] = cmt_reg_o;
        cmt_dat_l[cmt_n] = cmt_data_o;
        cmt_n++;
      end
      if (cmt_exc_o) exc_n++;
    end
  end

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic disp(input logic [3:0] op, input logic s1r, input logic [15:0] s1,
                      input logic s2r, input logic [15:0] s2, input logic [4:0] dst,
                      output logic [2:0] tag);
    disp_valid_i = 1'b1; disp_op_i = op; disp_dst_i = dst;
    disp_s1_rdy_i = s1r; disp_s1_i = s1; disp_s2_rdy_i = s2r; disp_s2_i = s2;
    #1;
    chk_eq("R2 dispatch accepted", disp_ready_o, 1);
    chk_eq("R2 slot tag", disp_tag_o, exp_tag);
    tag = disp_tag_o;
    exp_tag = exp_tag + 3'd1;
    @(negedge clk_i);
    disp_valid_i = 1'b0;
  endtask

  task automatic complete(input logic [2:0] tag, input logic [15:0] data, input logic exc);
    cmp_valid_i = 1'b1; cmp_tag_i = tag; cmp_data_i = data; cmp_exc_i = exc;
    @(negedge clk_i);
    cmp_valid_i = 1'b0; cmp_exc_i = 1'b0;
  endtask

  task automatic test_reset;
    #1;
    chk_eq("R1 ready", disp_ready_o, 1);
    chk_eq("R1 tag", disp_tag_o, 0);
    chk_eq("R1 issue", iss_valid_o, 0);
    chk_eq("R1 commit", cmt_valid_o, 0);
    chk_eq("R1 exc", cmt_exc_o, 0);
    @(negedge clk_i);
  endtask

  task automatic test_basic;
    int i0 = iss_n; int c0 = cmt_n; logic [2:0] t;
    disp(4'd3, 1, 16'h0011, 1, 16'h0022, 5'd5, t);
    step(3);
    chk_eq("R3 issued once", iss_n - i0, 1);
    chk_eq("R3 issue tag", iss_tag_l[i0], t);
    chk_eq("R3 issue op", iss_op_l[i0], 3);
    chk_eq("R3 issue s1", iss_s1_l[i0], 16'h0011);
    chk_eq("R3 issue s2", iss_s2_l[i0], 16'h0022);
    complete(t, 16'hABCD, 0);
    step(2);
    chk_eq("R7 one retire", cmt_n - c0, 1);
    chk_eq("R7 retire reg", cmt_reg_l[c0], 5);
    chk_eq("R7 retire data", cmt_dat_l[c0], 16'hABCD);
  endtask

  task automatic test_wake;
    int i0; int c0; logic [2:0] t, ta, tb, tc;
    while (exp_tag != 3'd6) begin
      disp(4'd0, 1, 16'h0, 1, 16'h0, 5'd0, t);
      step(1);
      complete(t, 16'h0, 0);
      step(1);
    end
    i0 = iss_n; c0 = cmt_n;
    disp(4'd1, 1, 16'h000A, 1, 16'h000B, 5'd1, ta);
    disp(4'd2, 0, {13'd0, ta}, 1, 16'h0007, 5'd2, tb);
    disp(4'd4, 0, {13'd0, ta}, 1, 16'h0008, 5'd3, tc);
    step(2);
    complete(ta, 16'h1234, 0);
    step(3);
    chk_eq("R5 three issues", iss_n - i0, 3);
    chk_eq("R4 oldest first across wrap", iss_tag_l[i0+1], tb);
    chk_eq("R4 younger second", iss_tag_l[i0+2], tc);
    chk_eq("R5 wake value B", iss_s1_l[i0+1], 16'h1234);
    chk_eq("R5 wake value C", iss_s1_l[i0+2], 16'h1234);
    chk_eq("R5 ready source kept", iss_s2_l[i0+2], 16'h0008);
    chk_eq("R7 producer retired", cmt_n - c0, 1);
    complete(tc, 16'hC0C0, 0);
    step(2);
    chk_eq("R7 younger waits", cmt_n - c0, 1);
    complete(tb, 16'hB0B0, 0);
    step(3);
    chk_eq("R7 retire count", cmt_n - c0, 3);
    chk_eq("R7 order reg B", cmt_reg_l[c0+1], 2);
    chk_eq("R7 order data B", cmt_dat_l[c0+1], 16'hB0B0);
    chk_eq("R7 order reg C", cmt_reg_l[c0+2], 3);
    chk_eq("R7 order data C", cmt_dat_l[c0+2], 16'hC0C0);
  endtask

  task automatic test_same;
    int i0; int c0 = cmt_n; logic [2:0] tp, td;
    disp(4'd5, 1, 16'h0001, 1, 16'h0002, 5'd6, tp);
    step(1);
    i0 = iss_n;
    cmp_valid_i = 1'b1; cmp_tag_i = tp; cmp_data_i = 16'h5A5A; cmp_exc_i = 1'b0;
    disp(4'd6, 0, {13'd0, tp}, 1, 16'h0003, 5'd7, td);
    cmp_valid_i = 1'b0;
    step(2);
    chk_eq("R6 captured source issues", iss_n - i0, 1);
    chk_eq("R6 issue tag", iss_tag_l[i0], td);
    chk_eq("R6 captured value", iss_s1_l[i0], 16'h5A5A);
    complete(td, 16'h0D0D, 0);
    step(3);
    chk_eq("R7 retire pair", cmt_n - c0, 2);
    chk_eq("R7 producer data", cmt_dat_l[c0], 16'h5A5A);
    chk_eq("R7 consumer reg", cmt_reg_l[c0+1], 7);
  endtask

  task automatic test_full;
    int c0 = cmt_n; logic [2:0] tg [8];
    for (int k = 0; k < 8; k++) disp(4'(k), 1, 16'(k), 1, 16'(k), 5'(k + 8), tg[k]);
    #1;
    chk_eq("R8 full not ready", disp_ready_o, 0);
    disp_valid_i = 1'b1; disp_dst_i = 5'd31;
    @(negedge clk_i);
    disp_valid_i = 1'b0;
    step(2);
    for (int k = 0; k < 8; k++) complete(tg[k], 16'h0100 + 16'(k), 0);
    step(4);
    chk_eq("R8 only eight retire", cmt_n - c0, 8);
    chk_eq("R8 last reg", cmt_reg_l[c0+7], 15);
    chk_eq("R8 last data", cmt_dat_l[c0+7], 16'h0107);
    chk_eq("R8 ready again", disp_ready_o, 1);
  endtask

  task automatic test_exc;
    int c0 = cmt_n; int x0 = exc_n; logic [2:0] e1, e2, e3, tn;
    disp(4'd7, 1, 16'h1, 1, 16'h1, 5'd9, e1);
    disp(4'd7, 1, 16'h2, 1, 16'h2, 5'd10, e2);
    disp(4'd7, 1, 16'h3, 1, 16'h3, 5'd11, e3);
    step(3);
    complete(e2, 16'h2222, 0);
    complete(e1, 16'hEEEE, 1);
    step(2);
    chk_eq("R9 exception pulse", exc_n - x0, 1);
    chk_eq("R9 no retire", cmt_n - c0, 0);
    complete(e3, 16'h3333, 0);
    step(2);
    chk_eq("R9 discarded slot silent", cmt_n - c0, 0);
    exp_tag = e1;
    disp(4'd8, 1, 16'h4, 1, 16'h4, 5'd12, tn);
    chk_eq("R9 tag reused", tn, e1);
    step(1);
    complete(tn, 16'h4242, 0);
    step(2);
    chk_eq("R9 resume retire", cmt_n - c0, 1);
    chk_eq("R9 resume reg", cmt_reg_l[c0], 12);
  endtask

  task automatic test_flush;
    int i0; int c0; logic [2:0] f1, f2, tg;
    i0 = iss_n;
    disp(4'd9, 0, {13'd0, exp_tag}, 1, 16'h0, 5'd20, f1);
    disp(4'd9, 0, {13'd0, exp_tag}, 1, 16'h0, 5'd21, f2);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
    exp_tag = f1;
    step(2);
    chk_eq("R10 nothing issued", iss_n - i0, 0);
    c0 = cmt_n;
    disp(4'd10, 1, 16'h9, 1, 16'h9, 5'd13, tg);
    chk_eq("R10 tag at retire pointer", tg, f1);
    step(1);
    complete(tg, 16'h1313, 0);
    step(2);
    chk_eq("R10 only new slot retires", cmt_n - c0, 1);
    chk_eq("R10 new slot reg", cmt_reg_l[c0], 13);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    test_reset;
    test_basic;
    test_wake;
    test_same;
    test_full;
    test_exc;
    test_flush;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule